// File: doc/BRIEF.md
# Converter Serial Slave with Partial Power-Down

This block is the digital half of the serial port on an eight-input, 12-bit successive-approximation converter. A host frames each transfer by pulling chip select low and then gives exactly sixteen serial clocks. During the frame the block shifts a command word in and a result word out. A parallel input bus stands in for the analog core and supplies one 12-bit code per input. The block samples that bus when a frame opens. The code is returned during the following frame, tagged with the number of the input it came from.

The command word can enable any subset of the inputs. The block then visits the enabled inputs in rising order, one per converting frame. A low-power state is entered when a command asks for it at the close of a frame, and it is left the same way. While asleep or waking, the block sends only ones. After waking it needs one frame to take its configuration before the first conversion. All serial pins are synchronised into the system clock domain, so the serial clock must run well below the system clock.

Top module: `adcsp_top`

## Requirements
- R1: After reset `ready` is high, `hold` is low, `dout` is low and no result is held, so the first frame returns 16'hFFFF.
- R2: A full frame shifts out 16 bits, most significant first. The first bit appears when the frame opens and each further bit follows a falling serial clock edge. The upper 4 bits give the input number and the lower 12 bits give the code that the previous completed converting frame sampled.
- R3: A converting frame samples the bus slice `conv_data[12*k +: 12]` of the selected input k at the falling edge of chip select. Changes to the bus later in the frame do not alter the returned code.
- R4: In a converting frame, `hold` goes high when the frame opens and falls at the 14th falling serial clock edge.
- R5: Command bits are sampled on falling serial clock edges, first bit = bit 15. Bit 15 is the write enable, bits 13:6 enable inputs 7..0 (bit 6+k enables input k) and bit 0 requests power-down. With bit 15 clear, none of these fields has any effect.
- R6: Converting frames visit the enabled inputs in rising order and wrap around. A write restarts the visit at the lowest enabled input. With no input enabled, input 0 is converted.
- R7: A frame that closes after any count of falling serial edges other than 16 changes neither the settings, the visit order, the held result nor the power state.
- R8: A completed write with bit 0 set puts the block to sleep at the close of that frame. `ready` then falls, and every later frame returns 16'hFFFF until the block is awake again.
- R9: A completed write with bit 0 clear, made while asleep, starts a wake-up at the close of the frame. `ready` rises WAKE_CYCLES system clocks later, and frames opened before that return 16'hFFFF.
- R10: The first frame opened after waking only takes configuration and returns 16'hFFFF. The next frame converts, also returning 16'hFFFF, and the frame after that returns valid data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial command data |
| conv_data | input | NCH*DW | Codes of all inputs, input k at bits DW*k +: DW |
| dout | output | 1 | Serial result data, low when no frame is open |
| hold | output | 1 | High while the sampled value is being held |
| ready | output | 1 | High when awake and able to convert |

## Verification
A wrong input pointer or mask shows up one frame later as a wrong 4-bit tag in the returned word. Because every conversion is echoed in the next frame, a fault in the sequencing state can be seen within two frames. A power state that is stuck or has slipped shows on `ready` right after the closing edge. It also shows in the next frame as an all-ones word where data was expected, or as data where all ones was expected. An aborted frame that leaks into state shows as a changed tag or a changed power level in the frames that follow it.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;
  typedef enum logic [1:0] {
    PWR_ON   = 2'd0,
    PWR_OFF  = 2'd1,
    PWR_WAKE = 2'd2
  } pwr_e;
endpackage

// File: rtl/adcsp_sync.sv
module adcsp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic sclk_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic din_s
);
  logic [STAGES-1:0] sclk_sh, cs_sh, din_sh;
  logic [STAGES-1:0] sclk_sh_d, cs_sh_d, din_sh_d;
  logic sclk_dly, cs_dly;

  always_comb begin
    sclk_sh_d = {sclk_sh[STAGES-2:0], sclk};
    cs_sh_d   = {cs_sh[STAGES-2:0], cs_n};
    din_sh_d  = {din_sh[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sh  <= '1;
      cs_sh    <= '1;
      din_sh   <= '0;
      sclk_dly <= 1'b1;
      cs_dly   <= 1'b1;
    end else begin
      sclk_sh  <= sclk_sh_d;
      cs_sh    <= cs_sh_d;
      din_sh   <= din_sh_d;
      sclk_dly <= sclk_sh[STAGES-1];
      cs_dly   <= cs_sh[STAGES-1];
    end
  end

  assign sclk_fall = sclk_dly & ~sclk_sh[STAGES-1];
  assign cs_fall   = cs_dly & ~cs_sh[STAGES-1];
  assign cs_rise   = ~cs_dly & cs_sh[STAGES-1];
  assign din_s     = din_sh[STAGES-1];
endmodule

// File: rtl/adcsp_frame.sv
module adcsp_frame #(
  parameter int FB         = 16,
  parameter int NCH        = 8,
  parameter int SEL_LSB    = 6,
  parameter int TRACK_EDGE = 14,
  parameter int CNTW       = $clog2(FB + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_fall,
  input  logic            cs_rise,
  input  logic            sclk_fall,
  input  logic            din_s,
  input  logic            conv_ok,
  input  logic [FB-1:0]   tx_load,
  output logic            dout,
  output logic            hold,
  output logic            act,
  output logic            frame_done,
  output logic [CNTW-1:0] bit_cnt,
  output logic            wr_bit,
  output logic            ppd_bit,
  output logic [NCH-1:0]  sel
);
  localparam logic [CNTW-1:0] FULL_CNT  = CNTW'(FB);
  localparam logic [CNTW-1:0] OVER_CNT  = CNTW'(FB + 1);
  localparam logic [CNTW-1:0] TRACK_CNT = CNTW'(TRACK_EDGE - 1);

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [FB-1:0]   rx_q, rx_d, tx_q, tx_d;
  logic            act_q, act_d, hold_q, hold_d;

  always_comb begin
    cnt_d  = cnt_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    act_d  = act_q;
    hold_d = hold_q;
    if (cs_fall) begin
      act_d  = 1'b1;
      cnt_d  = '0;
      tx_d   = tx_load;
      hold_d = conv_ok;
    end else if (cs_rise) begin
      act_d  = 1'b0;
      hold_d = 1'b0;
    end else if (sclk_fall && act_q) begin
      rx_d = {rx_q[FB-2:0], din_s};
      tx_d = {tx_q[FB-2:0], 1'b1};
      if (cnt_q <= FULL_CNT) cnt_d = cnt_q + 1'b1;
      if (cnt_q == TRACK_CNT) hold_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= OVER_CNT;
      rx_q   <= '0;
      tx_q   <= '0;
      act_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      act_q  <= act_d;
      hold_q <= hold_d;
    end
  end

  assign dout       = act_q & tx_q[FB-1];
  assign hold       = hold_q;
  assign act        = act_q;
  assign bit_cnt    = cnt_q;
  assign frame_done = cs_rise & act_q & (cnt_q == FULL_CNT);
  assign wr_bit     = rx_q[FB-1];
  assign ppd_bit    = rx_q[0];
  assign sel        = rx_q[SEL_LSB+NCH-1:SEL_LSB];
endmodule

// File: rtl/adcsp_pwr.sv
module adcsp_pwr
  import adcsp_pkg::*;
#(
  parameter int WAKE_CYCLES = 200,
  parameter int WCW         = $clog2(WAKE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_fall,
  input  logic frame_done,
  input  logic wr_bit,
  input  logic ppd_bit,
  output pwr_e state,
  output logic conv_ok,
  output logic frame_conv,
  output logic off_enter
);
  localparam logic [WCW-1:0] WAKE_LOAD = WCW'(WAKE_CYCLES - 1);

  pwr_e           state_q, state_d;
  logic [WCW-1:0] wcnt_q, wcnt_d;
  logic           prime_q, prime_d, conv_q, conv_d, pf_q, pf_d;

  assign conv_ok   = (state_q == PWR_ON) && !prime_q;
  assign off_enter = frame_done & wr_bit & ppd_bit;

  always_comb begin
    state_d = state_q;
    wcnt_d  = wcnt_q;
    prime_d = prime_q;
    conv_d  = conv_q;
    pf_d    = pf_q;
    if (cs_fall) begin
      conv_d = conv_ok;
      pf_d   = (state_q == PWR_ON) && prime_q;
    end
    if (state_q == PWR_WAKE) begin
      if (wcnt_q == '0) begin
        state_d = PWR_ON;
        prime_d = 1'b1;
      end else begin
        wcnt_d = wcnt_q - 1'b1;
      end
    end
    if (frame_done) begin
      if (pf_q) prime_d = 1'b0;
      if (wr_bit) begin
        if (ppd_bit) begin
          state_d = PWR_OFF;
          prime_d = 1'b0;
        end else if (state_q == PWR_OFF) begin
          state_d = PWR_WAKE;
          wcnt_d  = WAKE_LOAD;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PWR_ON;
      wcnt_q  <= '0;
      prime_q <= 1'b0;
      conv_q  <= 1'b0;
      pf_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      prime_q <= prime_d;
      conv_q  <= conv_d;
      pf_q    <= pf_d;
    end
  end

  assign state      = state_q;
  assign frame_conv = conv_q;
endmodule

// File: rtl/adcsp_chan.sv
module adcsp_chan #(
  parameter int NCH = 8,
  parameter int DW  = 12,
  parameter int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              frame_done,
  input  logic              wr_bit,
  input  logic              frame_conv,
  input  logic [NCH-1:0]    sel,
  input  logic [NCH*DW-1:0] conv_data,
  output logic [NCH-1:0]    mask,
  output logic [CHW-1:0]    samp_id,
  output logic [DW-1:0]     samp
);
  logic [NCH-1:0] mask_q, mask_d;
  logic [CHW-1:0] ptr_q, ptr_d, sid_q, sid_d;
  logic [DW-1:0]  samp_q, samp_d;

  function automatic logic [CHW-1:0] lowest_en(input logic [NCH-1:0] m);
    logic [CHW-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (m[i]) r = CHW'(i);
    end
    return r;
  endfunction

  function automatic logic [CHW-1:0] after_en(input logic [NCH-1:0] m,
                                              input logic [CHW-1:0] p);
    logic [CHW-1:0] r;
    logic           hit;
    r   = '0;
    hit = 1'b0;
    for (int k = 1; k <= NCH; k++) begin
      int idx;
      idx = (int'(p) + k) % NCH;
      if (!hit && m[idx]) begin
        r   = CHW'(idx);
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  always_comb begin
    mask_d = mask_q;
    ptr_d  = ptr_q;
    sid_d  = sid_q;
    samp_d = samp_q;
    if (cs_fall) begin
      samp_d = conv_data[int'(ptr_q)*DW +: DW];
      sid_d  = ptr_q;
    end
    if (frame_done) begin
      if (wr_bit) begin
        mask_d = sel;
        ptr_d  = lowest_en(sel);
      end else if (frame_conv) begin
        ptr_d = after_en(mask_q, ptr_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ptr_q  <= '0;
      sid_q  <= '0;
      samp_q <= '0;
    end else begin
      mask_q <= mask_d;
      ptr_q  <= ptr_d;
      sid_q  <= sid_d;
      samp_q <= samp_d;
    end
  end

  assign mask    = mask_q;
  assign samp_id = sid_q;
  assign samp    = samp_q;
endmodule

// File: rtl/adcsp_top.sv
module adcsp_top
  import adcsp_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int DW          = 12,
  parameter int IDW         = 4,
  parameter int SEL_LSB     = 6,
  parameter int TRACK_EDGE  = 14,
  parameter int WAKE_CYCLES = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  input  logic [NCH*DW-1:0] conv_data,
  output logic              dout,
  output logic              hold,
  output logic              ready
);
  localparam int FB   = IDW + DW;
  localparam int CHW  = $clog2(NCH);
  localparam int CNTW = $clog2(FB + 2);

  logic            sclk_fall, cs_fall, cs_rise, din_s;
  logic            frm_act, frm_done, rx_wr, rx_ppd, conv_ok, frame_conv, off_enter;
  logic [CNTW-1:0] bit_cnt;
  logic [NCH-1:0]  rx_sel, ch_mask;
  logic [CHW-1:0]  samp_id;
  logic [DW-1:0]   samp;
  pwr_e            pwr_state;
  logic [FB-1:0]   res_q, res_d, tx_load;
  logic            vld_q, vld_d;

  adcsp_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .sclk_fall(sclk_fall), .cs_fall(cs_fall), .cs_rise(cs_rise), .din_s(din_s)
  );

  adcsp_frame #(
    .FB(FB), .NCH(NCH), .SEL_LSB(SEL_LSB), .TRACK_EDGE(TRACK_EDGE), .CNTW(CNTW)
  ) frame_i (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .din_s(din_s), .conv_ok(conv_ok), .tx_load(tx_load),
    .dout(dout), .hold(hold), .act(frm_act), .frame_done(frm_done),
    .bit_cnt(bit_cnt), .wr_bit(rx_wr), .ppd_bit(rx_ppd), .sel(rx_sel)
  );

  adcsp_pwr #(.WAKE_CYCLES(WAKE_CYCLES)) pwr_i (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .frame_done(frm_done),
    .wr_bit(rx_wr), .ppd_bit(rx_ppd), .state(pwr_state), .conv_ok(conv_ok),
    .frame_conv(frame_conv), .off_enter(off_enter)
  );

  adcsp_chan #(.NCH(NCH), .DW(DW)) chan_i (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .frame_done(frm_done),
    .wr_bit(rx_wr), .frame_conv(frame_conv), .sel(rx_sel), .conv_data(conv_data),
    .mask(ch_mask), .samp_id(samp_id), .samp(samp)
  );

  assign tx_load = (pwr_state == PWR_ON && vld_q) ? res_q : '1;

  always_comb begin
    res_d = res_q;
    vld_d = vld_q;
    if (frm_done) begin
      res_d = {IDW'(samp_id), samp};
      vld_d = frame_conv && !off_enter;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign ready = (pwr_state == PWR_ON);
endmodule

// File: rtl/adcsp_chk.sv
module adcsp_chk
  import adcsp_pkg::*;
#(
  parameter int FB  = 16,
  parameter int NCH = 8,
  parameter int TRACK_EDGE = 14,
  parameter int CNTW = $clog2(FB + 2)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            act,
  input logic            dout,
  input logic            hold,
  input logic            frame_done,
  input logic            wr_bit,
  input logic [CNTW-1:0] bit_cnt,
  input pwr_e            state,
  input logic [NCH-1:0]  mask
);
  // R8
  asleep_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PWR_ON && act) |-> dout);

  // R4
  hold_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> act);

  // R4
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hold) && act) |-> (bit_cnt == CNTW'(TRACK_EDGE)));

  // R5
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask) |-> $past(frame_done && wr_bit));

  // R7
  state_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(state) |-> ($past(frame_done) || $past(state) == PWR_WAKE));

  // R7
  edge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNTW'(FB + 1));
endmodule

bind adcsp_top adcsp_chk #(.FB(IDW + DW), .NCH(NCH), .TRACK_EDGE(TRACK_EDGE)) chk_i (
  .clk(clk), .rst_n(rst_n), .act(frm_act), .dout(dout), .hold(hold),
  .frame_done(frm_done), .wr_bit(rx_wr), .bit_cnt(bit_cnt),
  .state(pwr_state), .mask(ch_mask)
);

// File: tb/adcsp_top_tb_top.sv
module adcsp_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int DW  = 12;
  localparam int W   = 200;

  logic clk = 1'b0;
  logic rst_n, sclk, cs_n, din;
  logic [NCH*DW-1:0] conv_data;
  logic dout, hold, ready;

  int unsigned cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int st;
  logic [7:0]  m_mask;
  int          m_ptr;
  logic [15:0] m_res;
  bit          m_vld, m_prime;
  int unsigned t_wake;

  adcsp_top #(.NCH(NCH), .DW(DW), .WAKE_CYCLES(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .conv_data(conv_data), .dout(dout), .hold(hold), .ready(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic int low_en(input logic [7:0] m);
    for (int i = 0; i < NCH; i++) if (m[i]) return i;
    return 0;
  endfunction

  function automatic int nxt_en(input logic [7:0] m, input int p);
    for (int k = 1; k <= NCH; k++) if (m[(p + k) % NCH]) return (p + k) % NCH;
    return 0;
  endfunction

  task automatic settle();
    if (st == 2 && cyc >= t_wake + W + 10) begin
      st = 0;
      m_prime = 1'b1;
    end
  endtask

  task automatic new_data();
    for (int i = 0; i < NCH; i++) conv_data[i*DW +: DW] = 12'($urandom);
  endtask

  task automatic do_frame(input logic [15:0] w, input int nedges, input bit bump, input string tag);
    logic [15:0] expw, got;
    bit conv, pf;
    logic [11:0] smp;
    int sptr;
    if (st == 2 && cyc + 10 >= t_wake + W) wclk(30);
    settle();
    expw = (st == 0 && m_vld) ? m_res : 16'hFFFF;
    conv = (st == 0) && !m_prime;
    pf   = (st == 0) && m_prime;
    sptr = m_ptr;
    smp  = conv_data[m_ptr*DW +: DW];
    got  = '0;
    cs_n = 1'b0;
    wclk(8);
    if (bump) conv_data = ~conv_data;
    for (int n = 1; n <= nedges; n++) begin
      din = w[16-n];
      wclk(4);
      got[16-n] = dout;
      if (conv && nedges == 16 && (n == 1 || n == 14))
        chk(hold === 1'b1, "R4 hold high before 14th edge", 32'(hold), 1);
      if (conv && nedges == 16 && n == 15)
        chk(hold === 1'b0, "R4 hold low after 14th edge", 32'(hold), 0);
      sclk = 1'b0;
      wclk(8);
      sclk = 1'b1;
      wclk(8);
    end
    cs_n = 1'b1;
    wclk(10);
    if (nedges == 16) begin
      chk(got === expw, tag, 32'(got), 32'(expw));
      settle();
      m_res = {4'(sptr), smp};
      m_vld = conv;
      if (pf) m_prime = 1'b0;
      if (w[15]) begin
        m_mask = w[13:6];
        m_ptr  = low_en(m_mask);
        if (w[0]) begin
          st = 1;
          m_vld = 1'b0;
          m_prime = 1'b0;
        end else if (st == 1) begin
          st = 2;
          t_wake = cyc;
        end
      end else if (conv) begin
        m_ptr = nxt_en(m_mask, m_ptr);
      end
    end
    if (!(st == 2 && cyc + 10 >= t_wake + W))
      chk(ready === (st == 0), {tag, " / R8 R9 ready level"}, 32'(ready), 32'(st == 0));
  endtask

  function automatic logic [15:0] cmd(input bit wr, input logic [7:0] sel, input bit ppd);
    return {wr, 1'b0, sel, 5'b0, ppd};
  endfunction

  initial begin
    rst_n = 1'b0; sclk = 1'b1; cs_n = 1'b1; din = 1'b0;
    void'($urandom(32'h5eed_0042));
    new_data();
    st = 0; m_mask = '0; m_ptr = 0; m_res = '0; m_vld = 0; m_prime = 0; t_wake = 0;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    chk(ready === 1'b1, "R1 ready after reset", 32'(ready), 1);
    chk(hold === 1'b0, "R1 hold after reset", 32'(hold), 0);
    chk(dout === 1'b0, "R1 dout idle after reset", 32'(dout), 0);
    do_frame(16'h0000, 16, 0, "R1 first frame all ones");
    do_frame(cmd(1, 8'b0010_0100, 0), 16, 0, "R5 write enables inputs 2 and 5");
    do_frame(16'h0000, 16, 0, "R2 result tag and code of input 0");
    do_frame(16'h0000, 16, 0, "R6 visit input 2");
    do_frame(16'h0000, 16, 0, "R6 visit input 5");
    do_frame(16'h7FFE, 16, 0, "R6 wrap to input 2");
    do_frame(16'h0000, 16, 0, "R5 fields ignored without write bit");
    do_frame(16'h0000, 16, 1, "R3 bus changed mid-frame");
    do_frame(16'h0000, 16, 0, "R3 code sampled at frame open");
    do_frame(cmd(1, 8'hFF, 1), 10, 0, "R7 aborted frame");
    do_frame(16'h0000, 16, 0, "R7 abort left no trace");
    do_frame(cmd(1, 8'h00, 0), 16, 0, "R6 empty mask write");
    do_frame(16'h0000, 16, 0, "R6 empty mask uses input 0");
    do_frame(16'h0000, 16, 0, "R6 input 0 again");
    do_frame(cmd(1, 8'hFF, 1), 16, 0, "R8 enter sleep");
    do_frame(16'h0000, 16, 0, "R8 all ones while asleep");
    do_frame(cmd(0, 8'h00, 0), 16, 0, "R8 no write keeps sleep");
    do_frame(cmd(1, 8'h81, 0), 16, 0, "R9 wake write");
    chk(ready === 1'b0, "R9 not ready just after wake write", 32'(ready), 0);
    do_frame(16'h0000, 16, 0, "R9 all ones during wake");
    do_frame(cmd(1, 8'h18, 0), 16, 0, "R10 configuration frame");
    do_frame(16'h0000, 16, 0, "R10 converting frame");
    do_frame(16'h0000, 16, 0, "R10 fourth frame valid");
    chk(m_vld == 1'b1, "R10 model expects valid data", 32'(m_vld), 1);
    for (int f = 0; f < 150; f++) begin
      logic [15:0] w;
      int ne;
      new_data();
      w = 16'($urandom);
      w[0] = ($urandom % 6 == 0);
      if (st == 1 && ($urandom % 3 == 0)) begin w[15] = 1'b1; w[0] = 1'b0; end
      ne = ($urandom % 8 == 0) ? int'($urandom % 16) : 16;
      do_frame(w, ne, 0, "R2 R6 R7 random frame");
      if (st == 2 && ($urandom % 2 == 0)) wclk(W + 20);
      else wclk(int'($urandom % 20));
    end
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule